// File: doc/BRIEF.md
# Single-Bank Prioritised Interrupt Controller

This block gathers 32 active-high interrupt request lines and presents two interrupt outputs to a processor: a normal-class output and a fast-class output. Each line is configured independently for edge or level detection, a 5-bit priority (0 is the most urgent) and its class. Requests latch into a pending register, are filtered by a mask register, and the unmasked pending lines of each class are ranked by a priority arbiter that runs continuously.

Each class has an arm flag. While armed, the first cycle that shows an unmasked pending line of that class raises the class output, captures the winning line index into that class's code register and disarms the class. The output then stays high, whatever happens to the pending lines, until software writes the matching bit of the control register. That write lowers the output and re-arms the class, so the class is evaluated again. Reading a code register returns the captured index and, if that line is edge-sensed, clears its pending bit.

Software uses a simple port with valid, write, an 8-bit byte address and 32-bit data. Writes take effect at the clock edge where valid is high. Read data is combinational, valid in the same cycle as the read, and any side effect of a read occurs at that edge. The software-trigger register lets software set a pending bit directly.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the mask register (0x04) reads 0xFFFFFFFF. Pending (0x00), both code registers (0x10 normal, 0x14 fast) and every line config word read 0. Both classes are armed and both outputs are low.
- R2: An edge-sensed line sets its pending bit only on the clock edge where its input is high and was low at the previous edge. An input held high does not set the bit again after the bit has been cleared.
- R3: A level-sensed line sets its pending bit on every edge where its input is high, and clears it on an edge where its input is low.
- R4: A write to pending (0x00) ANDs the register with the written data. Bits of level-sensed lines whose input is high at that edge are kept. If a set and a clear of the same bit fall on the same edge, the set wins.
- R5: The mask register (0x04) is read/write, with 1 meaning masked. A masked pending line never raises an output and never wins arbitration.
- R6: Among unmasked pending lines of one class, the line with the numerically lowest priority wins. On a tie the higher line index wins. Lines of the other class are not considered.
- R7: On the first edge where a class is armed and has an unmasked pending line, its output goes high, its code register captures the winner and the class disarms. The output then stays high until re-armed.
- R8: A write to control (0x18) with bit 0 set lowers the normal output and re-arms it at that edge; bit 1 does the same for the fast output. An eligible line raises the output again one edge later.
- R9: A read of a code register returns the captured index in bits 4:0. If that line is edge-sensed its pending bit clears at the edge of the read; a level-sensed line keeps it.
- R10: A write to the software-trigger register (0x9C) sets the pending bit of only the lowest set bit of the written data.
- R11: The config word of line n is at 0x1C + 4n. Bit 0 selects the fast class, bit 1 selects level sensing (0 = edge), bits 6:2 hold the priority and all other bits read 0.
- R12: The control and software-trigger registers read 0. An access to any other offset, or to an address with bits 1:0 not zero, reads 0 and its write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 32 | Interrupt request lines, active high |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_normal_o | output | 1 | Normal-class interrupt output |
| irq_fast_o | output | 1 | Fast-class interrupt output |

## Verification
The hardest case to reach from the ports is arbitration with several lines already pending. Because an armed class fires on the first edge where any line is eligible, two lines cannot both be pending at that moment unless something holds the arbiter back. The stimulus therefore masks every line, disarms and re-arms the class, sets two lines through the software-trigger register, and only then lowers the mask. Both lines become eligible on the same edge, so the priority order and the tie-break on higher index are both observed through the captured code.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int LINES  = 32;
  localparam int IDX_W  = $clog2(LINES);
  localparam int PRIO_W = 5;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int NCLS   = 2;

  localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CODE_N = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CODE_F = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CFG0   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CFGN   = OFS_CFG0 + ADDR_W'(4 * (LINES - 1));
  localparam logic [ADDR_W-1:0] OFS_SWTRIG = 8'h9C;

  localparam int CFG_W = PRIO_W + 2;

  // field order matches the config word, LSB = fast class
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              level;
    logic              fast;
  } line_cfg_t;
endpackage

// File: rtl/irq_sense.sv
module irq_sense
  import irq_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] level_i,
  input  logic             wr_pend_i,
  input  logic [LINES-1:0] wr_data_i,
  input  logic [LINES-1:0] rd_clr_i,
  input  logic [LINES-1:0] sw_set_i,
  output logic [LINES-1:0] pend_o
);
  logic [LINES-1:0] in_q, pend_q;
  logic [LINES-1:0] rise, set_v, clr_v, pend_d;

  always_comb begin
    rise   = req_i & ~in_q;
    set_v  = (level_i & req_i) | (~level_i & rise) | sw_set_i;
    clr_v  = rd_clr_i | (level_i & ~req_i);
    if (wr_pend_i) clr_v = clr_v | ~(wr_data_i | (req_i & level_i));
    pend_d = (pend_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      pend_q <= '0;
    end else begin
      in_q   <= req_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_ctrl_pkg::*;
(
  input  logic [LINES-1:0]             elig_i,
  input  logic [LINES-1:0][PRIO_W-1:0] prio_i,
  output logic                         any_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [PRIO_W-1:0] best_p;

  // ascending scan with <= lets the higher index win ties
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    best_p = '1;
    for (int i = 0; i < LINES; i++) begin
      if (elig_i[i] && (!any_o || prio_i[i] <= best_p)) begin
        any_o  = 1'b1;
        best_p = prio_i[i];
        idx_o  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  req_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_normal_o,
  output logic              irq_fast_o
);
  logic [LINES-1:0]             mask_q, level_q, fast_q, pend_q;
  logic [LINES-1:0][PRIO_W-1:0] prio_q;
  logic [NCLS-1:0]              armed_w, irq_w, code_rd;
  logic [IDX_W-1:0]             code_w [NCLS];

  logic              wr_en, rd_en, aligned, cfg_hit;
  logic [ADDR_W-1:0] cfg_ofs;
  logic [IDX_W-1:0]  cfg_idx;
  logic [LINES-1:0]  rd_clr, sw_set;

  assign wr_en   = bus_valid_i & bus_write_i;
  assign rd_en   = bus_valid_i & ~bus_write_i;
  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign cfg_hit = aligned && (bus_addr_i >= OFS_CFG0) && (bus_addr_i <= OFS_CFGN);
  assign cfg_ofs = bus_addr_i - OFS_CFG0;
  assign cfg_idx = cfg_ofs[IDX_W+1:2];

  // lowest set bit only
  assign sw_set = (wr_en && aligned && bus_addr_i == OFS_SWTRIG)
                ? (bus_wdata_i[LINES-1:0] & (~bus_wdata_i[LINES-1:0] + 1'b1)) : '0;

  assign code_rd[0] = rd_en && aligned && bus_addr_i == OFS_CODE_N;
  assign code_rd[1] = rd_en && aligned && bus_addr_i == OFS_CODE_F;

  always_comb begin
    rd_clr = '0;
    for (int c = 0; c < NCLS; c++)
      if (code_rd[c] && !level_q[code_w[c]]) rd_clr[code_w[c]] = 1'b1;
  end

  irq_sense u_sense (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .level_i   (level_q),
    .wr_pend_i (wr_en && aligned && bus_addr_i == OFS_PEND),
    .wr_data_i (bus_wdata_i[LINES-1:0]),
    .rd_clr_i  (rd_clr),
    .sw_set_i  (sw_set),
    .pend_o    (pend_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      level_q <= '0;
      fast_q  <= '0;
      prio_q  <= '0;
    end else if (wr_en) begin
      if (aligned && bus_addr_i == OFS_MASK) mask_q <= bus_wdata_i[LINES-1:0];
      if (cfg_hit) begin
        prio_q[cfg_idx]  <= bus_wdata_i[CFG_W-1:2];
        level_q[cfg_idx] <= bus_wdata_i[1];
        fast_q[cfg_idx]  <= bus_wdata_i[0];
      end
    end
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [LINES-1:0] elig;
    logic             any, rearm;
    logic [IDX_W-1:0] win;
    logic             armed_q, irq_q;
    logic [IDX_W-1:0] code_q;

    assign elig  = pend_q & ~mask_q & ((c == 1) ? fast_q : ~fast_q);
    assign rearm = wr_en && aligned && bus_addr_i == OFS_CTRL && bus_wdata_i[c];

    irq_prio_arb u_arb (
      .elig_i (elig),
      .prio_i (prio_q),
      .any_o  (any),
      .idx_o  (win)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        armed_q <= 1'b1;
        irq_q   <= 1'b0;
        code_q  <= '0;
      end else if (rearm) begin
        armed_q <= 1'b1;
        irq_q   <= 1'b0;
      end else if (armed_q && any) begin
        armed_q <= 1'b0;
        irq_q   <= 1'b1;
        code_q  <= win;
      end
    end

    assign armed_w[c] = armed_q;
    assign irq_w[c]   = irq_q;
    assign code_w[c]  = code_q;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en && aligned) begin
      case (bus_addr_i)
        OFS_PEND:   bus_rdata_o[LINES-1:0] = pend_q;
        OFS_MASK:   bus_rdata_o[LINES-1:0] = mask_q;
        OFS_CODE_N: bus_rdata_o[IDX_W-1:0] = code_w[0];
        OFS_CODE_F: bus_rdata_o[IDX_W-1:0] = code_w[1];
        default:
          if (cfg_hit)
            bus_rdata_o[CFG_W-1:0] = {prio_q[cfg_idx], level_q[cfg_idx], fast_q[cfg_idx]};
      endcase
    end
  end

  assign irq_normal_o = irq_w[0];
  assign irq_fast_o   = irq_w[1];
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LINES-1:0]  req_i,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              irq_normal_o,
  input logic              irq_fast_o,
  input logic [LINES-1:0]  pend_q,
  input logic [LINES-1:0]  mask_q,
  input logic [LINES-1:0]  level_q,
  input logic [LINES-1:0]  fast_q,
  input logic [NCLS-1:0]   armed_w
);
  logic ctrl_wr, rearm_n, rearm_f;
  logic [LINES-1:0] held;
  assign ctrl_wr = bus_valid_i && bus_write_i && bus_addr_i == OFS_CTRL;
  assign rearm_n = ctrl_wr && bus_wdata_i[0];
  assign rearm_f = ctrl_wr && bus_wdata_i[1];
  assign held    = pend_q & level_q & req_i;

  assert_rearm_low_n_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_n |=> !irq_normal_o);
  assert_rearm_low_f_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_f |=> !irq_fast_o);
  assert_hold_n_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_normal_o && !rearm_n) |=> irq_normal_o);
  assert_hold_f_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_fast_o && !rearm_f) |=> irq_fast_o);
  assert_fire_armed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_normal_o) |-> $past(armed_w[0]));
  assert_fire_unmasked_n_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_normal_o) |-> |($past(pend_q & ~mask_q & ~fast_q)));
  assert_fire_unmasked_f_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_fast_o) |-> |($past(pend_q & ~mask_q & fast_q)));
  assert_level_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(held)) == $past(held)));
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .irq_normal_o (irq_normal_o),
  .irq_fast_o   (irq_fast_o),
  .pend_q       (pend_q),
  .mask_q       (mask_q),
  .level_q      (level_q),
  .fast_q       (fast_q),
  .armed_w      (armed_w)
);

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ctrl_tb;
  localparam int TCK = 8;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  typedef struct packed {
    logic [23:0] tag;
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [31:0] req;
    logic [31:0] rd;
    logic        n;
    logic        f;
  } vec_t;

  function automatic vec_t mk(logic [23:0] tag, logic [1:0] op, logic [7:0] addr,
                              logic [31:0] wd, logic [31:0] req, logic [31:0] rd,
                              logic n, logic f);
    mk = '{tag, op, addr, wd, req, rd, n, f};
  endfunction

  localparam int NV = 50;
  localparam vec_t TBL [NV] = '{
    mk("R1 ", OP_RD,   8'h04, 0, 0, 32'hFFFF_FFFF, 0, 0),
    mk("R1 ", OP_RD,   8'h00, 0, 0, 0, 0, 0),
    mk("R5 ", OP_WR,   8'h04, 32'hFFFF_FFF0, 0, 0, 0, 0),
    mk("R11", OP_WR,   8'h24, 32'h0C, 0, 0, 0, 0),
    mk("R11", OP_WR,   8'h20, 32'h06, 0, 0, 0, 0),
    mk("R11", OP_WR,   8'h28, 32'h01, 0, 0, 0, 0),
    mk("R2 ", OP_RD,   8'h00, 0, 32'h4, 0, 0, 0),
    mk("R7 ", OP_IDLE, 8'h00, 0, 32'h4, 0, 1, 0),
    mk("R2 ", OP_RD,   8'h00, 0, 32'h4, 32'h4, 1, 0),
    mk("R9 ", OP_RD,   8'h10, 0, 0, 2, 1, 0),
    mk("R9 ", OP_RD,   8'h00, 0, 0, 0, 1, 0),
    mk("R7 ", OP_IDLE, 8'h00, 0, 32'h2, 0, 1, 0),
    mk("R8 ", OP_WR,   8'h18, 1, 32'h2, 0, 0, 0),
    mk("R8 ", OP_IDLE, 8'h00, 0, 32'h2, 0, 1, 0),
    mk("R4 ", OP_WR,   8'h00, 0, 32'h2, 0, 1, 0),
    mk("R4 ", OP_RD,   8'h00, 0, 32'h2, 32'h2, 1, 0),
    mk("R9 ", OP_RD,   8'h10, 0, 32'h2, 1, 1, 0),
    mk("R9 ", OP_RD,   8'h00, 0, 0, 32'h2, 1, 0),
    mk("R3 ", OP_RD,   8'h00, 0, 0, 0, 1, 0),
    mk("R10", OP_WR,   8'h9C, 32'h18, 0, 0, 1, 0),
    mk("R6 ", OP_IDLE, 8'h00, 0, 0, 0, 1, 1),
    mk("R9 ", OP_RD,   8'h14, 0, 0, 3, 1, 1),
    mk("R10", OP_RD,   8'h00, 0, 0, 0, 1, 1),
    mk("R5 ", OP_WR,   8'h04, 32'hFFFF_FFFF, 0, 0, 1, 1),
    mk("R8 ", OP_WR,   8'h18, 3, 0, 0, 0, 0),
    mk("R5 ", OP_WR,   8'h9C, 32'h4, 0, 0, 0, 0),
    mk("R5 ", OP_WR,   8'h9C, 32'h1, 0, 0, 0, 0),
    mk("R5 ", OP_WR,   8'h04, 32'hFFFF_FFF0, 0, 0, 0, 0),
    mk("R7 ", OP_IDLE, 8'h00, 0, 0, 0, 1, 0),
    mk("R6 ", OP_RD,   8'h10, 0, 0, 0, 1, 0),
    mk("R9 ", OP_RD,   8'h00, 0, 0, 32'h4, 1, 0),
    mk("R2 ", OP_IDLE, 8'h00, 0, 32'h4, 0, 1, 0),
    mk("R4 ", OP_WR,   8'h00, 0, 32'h4, 0, 1, 0),
    mk("R2 ", OP_IDLE, 8'h00, 0, 32'h4, 0, 1, 0),
    mk("R2 ", OP_RD,   8'h00, 0, 32'h4, 0, 1, 0),
    mk("R12", OP_WR,   8'h08, 32'hFFFF, 0, 0, 1, 0),
    mk("R12", OP_RD,   8'h08, 0, 0, 0, 1, 0),
    mk("R12", OP_RD,   8'h04, 0, 0, 32'hFFFF_FFF0, 1, 0),
    mk("R11", OP_RD,   8'h20, 0, 0, 32'h06, 1, 0),
    mk("R12", OP_RD,   8'h18, 0, 0, 0, 1, 0),
    mk("R12", OP_RD,   8'h9C, 0, 0, 0, 1, 0),
    mk("R11", OP_RD,   8'h28, 0, 0, 32'h01, 1, 0),
    mk("R6 ", OP_WR,   8'h1C, 32'h0C, 0, 0, 1, 0),
    mk("R6 ", OP_WR,   8'h04, 32'hFFFF_FFFF, 0, 0, 1, 0),
    mk("R6 ", OP_WR,   8'h9C, 32'h1, 0, 0, 1, 0),
    mk("R6 ", OP_WR,   8'h9C, 32'h4, 0, 0, 1, 0),
    mk("R8 ", OP_WR,   8'h18, 1, 0, 0, 0, 0),
    mk("R6 ", OP_WR,   8'h04, 32'hFFFF_FFF0, 0, 0, 0, 0),
    mk("R6 ", OP_IDLE, 8'h00, 0, 0, 0, 1, 0),
    mk("R6 ", OP_RD,   8'h10, 0, 0, 2, 1, 0)
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] req_i = '0;
  logic        bus_valid_i = 1'b0;
  logic        bus_write_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_normal_o, irq_fast_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(TCK/2) clk_i = ~clk_i;

  irq_ctrl u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .bus_valid_i  (bus_valid_i),
    .bus_write_i  (bus_write_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .irq_normal_o (irq_normal_o),
    .irq_fast_o   (irq_fast_o)
  );

  task automatic check(string what, logic [23:0] tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic access(logic [1:0] op, logic [7:0] a, logic [31:0] d, logic [31:0] r);
    @(negedge clk_i);
    req_i       = r;
    bus_valid_i = (op != OP_IDLE);
    bus_write_i = (op == OP_WR);
    bus_addr_i  = a;
    bus_wdata_i = d;
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("irq_normal in reset", "R1 ", {31'd0, irq_normal_o}, 0);
    check("irq_fast in reset", "R1 ", {31'd0, irq_fast_o}, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(TBL[i].op, TBL[i].addr, TBL[i].wd, TBL[i].req);
      #1;
      if (TBL[i].op == OP_RD) check("rdata", TBL[i].tag, bus_rdata_o, TBL[i].rd);
      @(posedge clk_i);
      #2;
      check("irq_normal", TBL[i].tag, {31'd0, irq_normal_o}, {31'd0, TBL[i].n});
      check("irq_fast", TBL[i].tag, {31'd0, irq_fast_o}, {31'd0, TBL[i].f});
    end

    // R1: reset again mid-run with state present
    access(OP_IDLE, 0, 0, 0);
    rst_ni = 1'b0;
    #2;
    check("irq_normal after reset", "R1 ", {31'd0, irq_normal_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    access(OP_RD, 8'h04, 0, 0);
    #1 check("mask after reset", "R1 ", bus_rdata_o, 32'hFFFF_FFFF);
    access(OP_RD, 8'h20, 0, 0);
    #1 check("cfg1 after reset", "R1 ", bus_rdata_o, 0);
    access(OP_RD, 8'h10, 0, 0);
    #1 check("code after reset", "R1 ", bus_rdata_o, 0);
    access(OP_RD, 8'h00, 0, 0);
    #1 check("pending after reset", "R1 ", bus_rdata_o, 0);

    // R12: unaligned mask write ignored
    access(OP_WR, 8'h05, 32'h0, 0);
    access(OP_RD, 8'h04, 0, 0);
    #1 check("unaligned write", "R12", bus_rdata_o, 32'hFFFF_FFFF);
    access(OP_IDLE, 0, 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule